// File: doc/BRIEF.md
# Bus traffic performance counter unit

This block sits next to one port of an on-chip bus and measures how busy that port is. It keeps a free-running cycle counter and four event counters. Each event counter counts read-data beats, write-data beats or, for the last counter only, both. Software compares the event counts with the cycle count to estimate how heavily the port is loaded. The beats arrive as single-cycle pulses, one input for read beats and one for write beats.

Software reaches the unit through a plain word-addressed register interface. A write takes effect on the clock edge where the write strobe is high, and read data is a combinational function of the address. A control word holds a global run bit, two self-clearing reset bits, a prescale select for the cycle counter and a start-mode field. Each counter also has its own enable bit. These enable bits are changed through a set address and a separate clear address, so software can change one bit without a read-modify-write. Every start-mode encoding is accepted and stored, but the unit always counts in the manual way. To take a consistent snapshot, software drops the global run bit and then reads the counters.

Top module: `perfmon_top`

## Requirements
- R1: After synchronous reset, every register reads as zero: control 0x04, enables 0x08/0x0C, all counters, and the type registers 0x200 to 0x20C. An address that maps to no register always reads zero.
- R2: Control (0x04) reads back bit 0 (global run), bit 3 (prescale select) and bits 21:20 (start mode). Bits 1 (event-counter reset) and 2 (cycle-counter reset) always read as zero.
- R3: A write to 0x08 sets every implemented enable bit that is written as one. A write to 0x0C clears every such bit. Both addresses read the current enables. Bits 3:0 are the event counters and bit 31 is the cycle counter; all other bits read zero.
- R4: A counter advances only in a cycle where both the global run bit and its own enable bit are already set.
- R5: Type register n sits at 0x200+4n and reads back its low 8 bits. Code 0x04 adds one per read beat. Code 0x05 adds one per write beat.
- R6: Code 0x22 makes event counter 3 add one for each read beat and one for each write beat, so it adds two in a cycle that has both. On counters 0 to 2, code 0x22 counts nothing. Code 0 and any other code count nothing.
- R7: The cycle counter (0x48) adds one every enabled clock when prescale select is 0. When prescale select is 1, it adds one once every 64 enabled clocks.
- R8: A control write with bit 1 set clears all event counters at that edge, and the cycle counter is left alone. If the same write sets the run bit, counting starts from zero in the next cycle.
- R9: A control write with bit 2 set clears the cycle counter and its prescale phase at that edge, and the event counters are left alone.
- R10: Event counters 0 to 2 read at 0x34, 0x38 and 0x3C. Event counter 3 is WIDE_W bits (40 by default). Its low CNT_W bits read at 0x40 and its remaining upper bits read from bit 0 of 0x44. Writes to counter addresses are ignored.
- R11: Every counter wraps to zero after its all-ones value.
- R12: While the global run bit is clear, every count holds steady, whatever beats arrive.
- R13: Start modes 1 (auto) and 2 (conditional interrupt) count exactly as mode 0 (manual).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| rd_beat | input | 1 | One read-data beat this cycle |
| wr_beat | input | 1 | One write-data beat this cycle |

## Verification
The counter assertions assume that beats are single-cycle levels sampled at the clock edge, and that the bus never sets and clears enables in the same cycle. The bus interface allows only one write per cycle, so the second condition holds by construction. The stimulus drives every input half a cycle away from the edge and issues at most one register write per cycle. The counters are shrunk to 8 and 12 bits through parameters, so wrap-around and the split high word of counter 3 can be reached within a short run.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;

    localparam int NUM_EVT = 4;
    localparam int EN_CYC_BIT = 31;

    localparam logic [11:0] ADDR_CTRL     = 12'h004;
    localparam logic [11:0] ADDR_EN_SET   = 12'h008;
    localparam logic [11:0] ADDR_EN_CLR   = 12'h00C;
    localparam logic [11:0] ADDR_EVT_BASE = 12'h034;
    localparam logic [11:0] ADDR_EVT3_LO  = 12'h040;
    localparam logic [11:0] ADDR_EVT3_HI  = 12'h044;
    localparam logic [11:0] ADDR_CYC      = 12'h048;
    localparam logic [11:0] ADDR_TYPE     = 12'h200;

    localparam logic [7:0] CODE_RD = 8'h04;
    localparam logic [7:0] CODE_WR = 8'h05;
    localparam logic [7:0] CODE_RW = 8'h22;

    typedef enum logic [1:0] {
        MODE_MANUAL = 2'd0,
        MODE_AUTO   = 2'd1,
        MODE_COND   = 2'd2,
        MODE_RSVD   = 2'd3
    } start_mode_e;

    typedef struct packed {
        start_mode_e mode;
        logic        presel;
        logic        run;
    } ctrl_t;

    typedef struct packed {
        logic rd;
        logic wr;
    } evt_sel_t;

    function automatic evt_sel_t decode_type(input logic [7:0] code, input logic rw_ok);
        evt_sel_t s;
        s = '0;
        if (code == CODE_RD) s.rd = 1'b1;
        else if (code == CODE_WR) s.wr = 1'b1;
        else if (code == CODE_RW && rw_ok) begin
            s.rd = 1'b1;
            s.wr = 1'b1;
        end
        return s;
    endfunction

    function automatic logic [31:0] pack_ctrl(input ctrl_t c);
        logic [31:0] w;
        w = '0;
        w[0] = c.run;
        w[3] = c.presel;
        w[21:20] = c.mode;
        return w;
    endfunction

    function automatic logic [11:0] evt_addr(input int n);
        return ADDR_EVT_BASE + 12'(4 * n);
    endfunction

    function automatic logic [11:0] type_addr(input int n);
        return ADDR_TYPE + 12'(4 * n);
    endfunction

endpackage

// File: rtl/perfmon_regs.sv
module perfmon_regs
    import perfmon_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output ctrl_t             ctrl,
    output logic [NUM_EVT-1:0] evt_en,
    output logic              cyc_en,
    output logic [7:0]        evt_type [NUM_EVT],
    output logic              evt_clr,
    output logic              cyc_clr
);

    localparam logic [NUM_EVT-1:0] ALL_EVT = '1;

    logic ctrl_hit;
    logic set_hit;
    logic clr_hit;

    assign ctrl_hit = wr_en && (addr == ADDR_W'(ADDR_CTRL));
    assign set_hit  = wr_en && (addr == ADDR_W'(ADDR_EN_SET));
    assign clr_hit  = wr_en && (addr == ADDR_W'(ADDR_EN_CLR));
    assign evt_clr  = ctrl_hit && wdata[1];
    assign cyc_clr  = ctrl_hit && wdata[2];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            evt_en <= '0;
            cyc_en <= 1'b0;
        end else begin
            if (ctrl_hit) begin
                ctrl.run    <= wdata[0];
                ctrl.presel <= wdata[3];
                ctrl.mode   <= start_mode_e'(wdata[21:20]);
            end
            if (set_hit) begin
                evt_en <= evt_en | (wdata[NUM_EVT-1:0] & ALL_EVT);
                cyc_en <= cyc_en | wdata[EN_CYC_BIT];
            end else if (clr_hit) begin
                evt_en <= evt_en & ~wdata[NUM_EVT-1:0];
                cyc_en <= cyc_en & ~wdata[EN_CYC_BIT];
            end
        end
    end

    for (genvar n = 0; n < NUM_EVT; n++) begin : g_type
        always_ff @(posedge clk) begin
            if (rst) begin
                evt_type[n] <= '0;
            end else if (wr_en && addr == ADDR_W'(type_addr(n))) begin
                evt_type[n] <= wdata[7:0];
            end
        end
    end

    // R3
    en_set_chk: assert property (@(posedge clk) disable iff (rst)
        set_hit |=> ((evt_en & $past(wdata[NUM_EVT-1:0])) == $past(wdata[NUM_EVT-1:0])));

    // R3
    en_clr_chk: assert property (@(posedge clk) disable iff (rst)
        clr_hit |=> ((evt_en & $past(wdata[NUM_EVT-1:0])) == '0));

endmodule

// File: rtl/perfmon_evt_counter.sv
module perfmon_evt_counter
    import perfmon_pkg::*;
#(
    parameter int W     = 32,
    parameter bit RW_OK = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         active,
    input  logic [7:0]   type_code,
    input  logic         rd_beat,
    input  logic         wr_beat,
    output logic [W-1:0] count
);

    evt_sel_t     sel;
    logic [W-1:0] step;

    assign sel  = decode_type(type_code, RW_OK);
    assign step = W'(sel.rd & rd_beat) + W'(sel.wr & wr_beat);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (active) begin
            count <= count + step;
        end
    end

    // R12
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!active && !clr) |=> $stable(count));

    // R8
    clr_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count == '0));

    // R6
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (active && !clr) |=> (W'(count - $past(count)) <= W'(2)));

endmodule

// File: rtl/perfmon_cycle_counter.sv
module perfmon_cycle_counter #(
    parameter int W        = 32,
    parameter int PRE_LOG2 = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         active,
    input  logic         presel,
    output logic [W-1:0] count
);

    logic [PRE_LOG2-1:0] phase;
    logic                tick;

    assign tick = !presel || (&phase);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
            phase <= '0;
        end else if (active) begin
            if (presel) phase <= phase + 1'b1;
            if (tick) count <= count + 1'b1;
        end
    end

    // R7
    every_clk_chk: assert property (@(posedge clk) disable iff (rst)
        (active && !presel && !clr) |=> (count == $past(count) + W'(1)));

    // R7
    presc_chk: assert property (@(posedge clk) disable iff (rst)
        (active && presel && !clr && !(&phase)) |=> $stable(count));

    // R9
    cyc_clr_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count == '0 && phase == '0));

endmodule

// File: rtl/perfmon_top.sv
module perfmon_top
    import perfmon_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int WIDE_W   = 40,
    parameter int ADDR_W   = 12,
    parameter int PRE_LOG2 = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              rd_beat,
    input  logic              wr_beat
);

    localparam int LAST = NUM_EVT - 1;

    ctrl_t               ctrl;
    logic [NUM_EVT-1:0]  evt_en;
    logic                cyc_en;
    logic [7:0]          evt_type [NUM_EVT];
    logic                evt_clr;
    logic                cyc_clr;
    logic [WIDE_W-1:0]   evt_cnt [NUM_EVT];
    logic [CNT_W-1:0]    cyc_cnt;
    logic [31:0]         en_word;

    perfmon_regs #(.ADDR_W(ADDR_W)) i_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .ctrl     (ctrl),
        .evt_en   (evt_en),
        .cyc_en   (cyc_en),
        .evt_type (evt_type),
        .evt_clr  (evt_clr),
        .cyc_clr  (cyc_clr)
    );

    for (genvar n = 0; n < NUM_EVT; n++) begin : g_evt
        localparam int  W_N  = (n == LAST) ? WIDE_W : CNT_W;
        localparam bit  RW_N = (n == LAST);
        logic [W_N-1:0] cnt_n;

        perfmon_evt_counter #(.W(W_N), .RW_OK(RW_N)) i_cnt (
            .clk       (clk),
            .rst       (rst),
            .clr       (evt_clr),
            .active    (ctrl.run && evt_en[n]),
            .type_code (evt_type[n]),
            .rd_beat   (rd_beat),
            .wr_beat   (wr_beat),
            .count     (cnt_n)
        );

        assign evt_cnt[n] = WIDE_W'(cnt_n);
    end

    perfmon_cycle_counter #(.W(CNT_W), .PRE_LOG2(PRE_LOG2)) i_cyc (
        .clk    (clk),
        .rst    (rst),
        .clr    (cyc_clr),
        .active (ctrl.run && cyc_en),
        .presel (ctrl.presel),
        .count  (cyc_cnt)
    );

    always_comb begin
        en_word = '0;
        en_word[NUM_EVT-1:0] = evt_en;
        en_word[EN_CYC_BIT] = cyc_en;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(ADDR_CTRL)) begin
            bus_rdata = pack_ctrl(ctrl);
        end else if (bus_addr == ADDR_W'(ADDR_EN_SET) || bus_addr == ADDR_W'(ADDR_EN_CLR)) begin
            bus_rdata = en_word;
        end else if (bus_addr == ADDR_W'(ADDR_EVT3_LO)) begin
            bus_rdata = 32'(evt_cnt[LAST][CNT_W-1:0]);
        end else if (bus_addr == ADDR_W'(ADDR_EVT3_HI)) begin
            bus_rdata = 32'(evt_cnt[LAST] >> CNT_W);
        end else if (bus_addr == ADDR_W'(ADDR_CYC)) begin
            bus_rdata = 32'(cyc_cnt);
        end else begin
            for (int n = 0; n < LAST; n++) begin
                if (bus_addr == ADDR_W'(evt_addr(n))) bus_rdata = 32'(evt_cnt[n][CNT_W-1:0]);
            end
            for (int n = 0; n < NUM_EVT; n++) begin
                if (bus_addr == ADDR_W'(type_addr(n))) bus_rdata = 32'(evt_type[n]);
            end
        end
    end

    // R2
    ctrl_rsv_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_W'(ADDR_CTRL)) |-> (bus_rdata[2:1] == 2'b00));

    // R12
    run_off_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.run && !cyc_clr) |=> $stable(cyc_cnt));

endmodule

// File: tb/test_perfmon_top.sv
`timescale 1ns/1ps
module test_perfmon_top;

    localparam int CNT_W  = 8;
    localparam int WIDE_W = 12;
    localparam longint CMASK = (64'd1 << CNT_W) - 1;
    localparam longint WMASK = (64'd1 << WIDE_W) - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rd_beat = 1'b0;
    logic        wr_beat = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    perfmon_top #(.CNT_W(CNT_W), .WIDE_W(WIDE_W)) i_perfmon_top (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rd_beat(rd_beat), .wr_beat(wr_beat)
    );

    // behavioural reference
    bit          m_run, m_presel;
    logic [1:0]  m_mode;
    logic [31:0] m_en;
    logic [7:0]  m_type [4];
    longint      m_evt [4];
    longint      m_cyc;
    int          m_pre;

    function automatic int beats_for(int n, bit rb, bit wb);
        int s = 0;
        if (m_type[n] == 8'h04 && rb) s = 1;
        if (m_type[n] == 8'h05 && wb) s = 1;
        if (n == 3 && m_type[n] == 8'h22) s = int'(rb) + int'(wb);
        return s;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_run = 0; m_presel = 0; m_mode = 0; m_en = 0; m_cyc = 0; m_pre = 0;
            for (int n = 0; n < 4; n++) begin m_evt[n] = 0; m_type[n] = 0; end
        end else begin
            if (m_run) begin
                for (int n = 0; n < 4; n++)
                    if (m_en[n]) m_evt[n] = (m_evt[n] + beats_for(n, rd_beat, wr_beat)) & ((n == 3) ? WMASK : CMASK);
                if (m_en[31]) begin
                    if (!m_presel) m_cyc = (m_cyc + 1) & CMASK;
                    else begin
                        if (m_pre == 63) m_cyc = (m_cyc + 1) & CMASK;
                        m_pre = (m_pre + 1) % 64;
                    end
                end
            end
            if (bus_wr) begin
                case (bus_addr)
                    12'h004: begin
                        m_run = bus_wdata[0]; m_presel = bus_wdata[3]; m_mode = bus_wdata[21:20];
                        if (bus_wdata[1]) for (int n = 0; n < 4; n++) m_evt[n] = 0;
                        if (bus_wdata[2]) begin m_cyc = 0; m_pre = 0; end
                    end
                    12'h008: m_en = m_en | (bus_wdata & 32'h8000_000F);
                    12'h00C: m_en = m_en & ~bus_wdata;
                    12'h200: m_type[0] = bus_wdata[7:0];
                    12'h204: m_type[1] = bus_wdata[7:0];
                    12'h208: m_type[2] = bus_wdata[7:0];
                    12'h20C: m_type[3] = bus_wdata[7:0];
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] m_read(logic [11:0] a);
        case (a)
            12'h004: return {10'd0, m_mode, 16'd0, 4'(m_presel) << 3 | 4'(m_run)};
            12'h008, 12'h00C: return m_en;
            12'h034: return 32'(m_evt[0]);
            12'h038: return 32'(m_evt[1]);
            12'h03C: return 32'(m_evt[2]);
            12'h040: return 32'(m_evt[3] & CMASK);
            12'h044: return 32'(m_evt[3] >> CNT_W);
            12'h048: return 32'(m_cyc);
            12'h200: return 32'(m_type[0]);
            12'h204: return 32'(m_type[1]);
            12'h208: return 32'(m_type[2]);
            12'h20C: return 32'(m_type[3]);
            default: return 32'd0;
        endcase
    endfunction

    // one clock: drive at negedge, compare read data, wait for the edge
    task automatic cyc(input bit w, input logic [11:0] a, input logic [31:0] d,
                       input bit rb, input bit wb, input string tag);
        @(negedge clk);
        bus_wr = w; bus_addr = a; bus_wdata = d; rd_beat = rb; wr_beat = wb;
        #1;
        checks++;
        if (bus_rdata !== m_read(a)) begin
            fails++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, bus_rdata, m_read(a));
        end
        @(posedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
        cyc(1'b1, a, d, 1'b0, 1'b0, tag);
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        cyc(1'b0, a, '0, 1'b0, 1'b0, tag);
    endtask

    task automatic run(input int n, input int rmod, input int wmod, input string tag);
        logic [11:0] list [7] = '{12'h034, 12'h038, 12'h03C, 12'h040, 12'h044, 12'h048, 12'h008};
        for (int i = 0; i < n; i++)
            cyc(1'b0, list[i % 7], '0, (i % rmod) == 0, (i % wmod) == 0, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R1 reset state and unmapped address
        foreach (i_addrs[k]) rd(i_addrs[k], "R1");
        rd(12'h100, "R1");
        // R5 and R6 types
        wr(12'h200, 32'h0000_0004, "R5");
        wr(12'h204, 32'h0000_0005, "R5");
        wr(12'h208, 32'h0000_0022, "R6");
        wr(12'h20C, 32'hFFFF_FF22, "R6");
        rd(12'h200, "R5"); rd(12'h204, "R5"); rd(12'h208, "R6"); rd(12'h20C, "R6");
        // R3 set and clear
        wr(12'h008, 32'hFFFF_FFFF, "R3");
        rd(12'h008, "R3"); rd(12'h00C, "R3");
        wr(12'h00C, 32'h0000_0002, "R3");
        rd(12'h00C, "R3");
        wr(12'h008, 32'h0000_0002, "R3");
        rd(12'h008, "R3");
        // R8 reset together with run
        wr(12'h004, 32'h0000_0007, "R8");
        run(40, 3, 5, "R4");
        run(20, 1, 1, "R6");
        // R12 hold with run off
        wr(12'h004, 32'h0000_0000, "R12");
        run(14, 1, 1, "R12");
        // R4 per-counter gate
        wr(12'h00C, 32'h0000_0001, "R4");
        wr(12'h004, 32'h0000_0001, "R4");
        run(21, 2, 3, "R4");
        wr(12'h008, 32'h0000_0001, "R4");
        // R10 writes to counters ignored
        wr(12'h034, 32'hFFFF_FFFF, "R10");
        wr(12'h048, 32'hFFFF_FFFF, "R10");
        // R7 prescale with cycle reset (R9)
        wr(12'h004, 32'h0000_000D, "R9");
        rd(12'h048, "R9");
        run(200, 4, 7, "R7");
        wr(12'h004, 32'h0000_0001, "R7");
        run(30, 2, 2, "R7");
        // R13 modes, R2 readback
        wr(12'h004, 32'h0010_000F, "R2");
        rd(12'h004, "R2");
        run(30, 2, 3, "R13");
        wr(12'h004, 32'h0020_0001, "R13");
        rd(12'h004, "R2");
        run(30, 3, 2, "R13");
        wr(12'h004, 32'h0030_0001, "R13");
        rd(12'h004, "R2");
        // R11 wrap, R10 high word
        run(560, 1, 1, "R11");
        // R8 event reset alone keeps cycle count
        wr(12'h004, 32'h0000_0003, "R8");
        rd(12'h048, "R8"); rd(12'h040, "R8"); rd(12'h044, "R10");
        run(14, 1, 2, "R8");
        // R9 cycle reset alone keeps event counts
        wr(12'h004, 32'h0000_0005, "R9");
        rd(12'h034, "R9");
        run(14, 1, 1, "R9");
        wr(12'h004, 32'h0000_0000, "R12");
        run(7, 1, 1, "R12");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    logic [11:0] i_addrs [13] = '{12'h004, 12'h008, 12'h00C, 12'h034, 12'h038, 12'h03C,
                                 12'h040, 12'h044, 12'h048, 12'h200, 12'h204, 12'h208, 12'h20C};

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule